// File: doc/BRIEF.md
# H-Bridge Gate Enable Sequencer with Synchronous Rectification

This block turns the state of a full-bridge chopper into four gate enables: a high-side (source) and a low-side (sink) switch on each of the two legs, called A and B. The polarity input picks the diagonal that carries current while the bridge is driving. During fast decay the crossed diagonal can be switched on so that the current flows through the transistors and not through their body diodes. During slow decay the two low-side switches can be closed together, which also brakes the motor. A 2-bit mode selects active, passive or disabled synchronous rectification. In passive mode the crossed pair is released once a zero-current flag rises.

Fault flags come after the path decoder. A hard fault (over-temperature, low regulator, low logic supply) forces every switch off. A low charge pump removes only the high-side enables. The result goes to a small sequencer. Outputs change only through a single all-off cycle, so a leg never sees overlapping enables during a transition.

The sequencer has three states. OFF: all outputs low, nothing held. ON: the held pattern is driven. BREAK: all outputs low for exactly one cycle. Its transitions are:
- OFF→ON when the gated target is non-zero; the target is loaded.
- ON→BREAK when the target differs from the held pattern.
- BREAK→ON when the target is non-zero; the target is loaded.
- BREAK→OFF when the target is zero.
- In every other case the state holds.

Top module: `hb_gate_decoder`

## Requirements
- R1: With decay code 2'b00 (drive), polarity 1 enables src_a and snk_b, and polarity 0 enables src_b and snk_a. The source enable of that diagonal is on only while the source latch input is high; the sink stays on regardless.
- R2: With decay code 2'b01 (fast) and mode 2'b10 (active), the crossed diagonal is on: polarity 1 gives src_b and snk_a, polarity 0 gives src_a and snk_b.
- R3: With fast decay and mode 2'b01 (passive), the crossed diagonal is on while zero_cur_i is low, and all outputs are off while it is high.
- R4: With mode 2'b00 or 2'b11 (disabled), fast decay turns all outputs off. Slow decay keeps only the sink of the drive diagonal: snk_b for polarity 1, snk_a for polarity 0.
- R5: With decay code 2'b10 (slow) and mode passive or active, snk_a and snk_b are both on and both sources are off. zero_cur_i has no effect.
- R6: Any of ot_flt_i, reg_low_i or vdd_low_i forces all four outputs off one cycle later, for as long as the flag stays high.
- R7: cp_low_i forces src_a and src_b off one cycle later. The sink enables keep their normal decoded values.
- R8: A leg never has its source and sink on together. Every change away from a non-zero output pattern passes through exactly one cycle with all outputs off before the new pattern appears.
- R9: Outputs are registered. While rst_n is low they are all off. Starting from all-off, a new pattern appears after the first rising edge that samples it.
- R10: Decay code 2'b11 is reserved and drives all outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | Polarity: 1 drives A high / B low |
| src_latch_i | input | 1 | Source-enable latch state from the current comparator |
| decay_i | input | 2 | 00 drive, 01 fast decay, 10 slow decay, 11 reserved |
| sr_mode_i | input | 2 | 00 disabled, 01 passive, 10 active, 11 disabled |
| zero_cur_i | input | 1 | Winding current has reached zero |
| ot_flt_i | input | 1 | Over-temperature fault |
| cp_low_i | input | 1 | Charge pump voltage low |
| reg_low_i | input | 1 | Low-side regulator voltage low |
| vdd_low_i | input | 1 | Logic supply low |
| src_a_o | output | 1 | High-side enable, leg A |
| src_b_o | output | 1 | High-side enable, leg B |
| snk_a_o | output | 1 | Low-side enable, leg A |
| snk_b_o | output | 1 | Low-side enable, leg B |

## Verification
Inputs change at a falling edge. A new pattern starting from all-off appears one rising edge later. A change from a non-zero pattern shows all-off one edge later and the new pattern one edge after that. Fault masking therefore takes effect at the first edge. The reference model in the bench advances on the same rising edge as the design and is compared at the following falling edge, so every cycle is checked against that timing. The directed checks wait three cycles after each input change, which is enough for any break to finish, and then compare against a fixed constant. The break checks sample the two edges right after the change.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        DEC_DRIVE = 2'b00,
        DEC_FAST  = 2'b01,
        DEC_SLOW  = 2'b10,
        DEC_RSVD  = 2'b11
    } decay_e;

    typedef enum logic [1:0] {
        SR_OFF     = 2'b00,
        SR_PASSIVE = 2'b01,
        SR_ACTIVE  = 2'b10,
        SR_RSVD    = 2'b11
    } sr_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_ON    = 2'b01,
        ST_BREAK = 2'b10
    } seq_e;

    typedef struct packed {
        logic src_a;
        logic src_b;
        logic snk_a;
        logic snk_b;
    } gates_t;

endpackage

// File: rtl/hb_path_decode.sv
module hb_path_decode
    import hb_gate_pkg::*;
(
    input  logic       phase,
    input  logic       src_latch,
    input  logic [1:0] decay,
    input  logic [1:0] sr_mode,
    input  logic       zero_cur,
    output gates_t     want
);
    logic sync_fast;
    logic sync_slow;

    // Synchronous rectification enable per decay type
    always_comb begin
        sync_fast = 1'b0;
        sync_slow = 1'b0;
        unique case (sr_mode_e'(sr_mode))
            SR_ACTIVE:  begin sync_fast = 1'b1;      sync_slow = 1'b1; end
            SR_PASSIVE: begin sync_fast = !zero_cur; sync_slow = 1'b1; end
            default:    begin sync_fast = 1'b0;      sync_slow = 1'b0; end
        endcase
    end

    always_comb begin
        want = '0;
        unique case (decay_e'(decay))
            DEC_DRIVE: begin
                want.src_a = phase & src_latch;
                want.snk_b = phase;
                want.src_b = !phase & src_latch;
                want.snk_a = !phase;
            end
            DEC_FAST: begin
                if (sync_fast) begin
                    want.src_b = phase;
                    want.snk_a = phase;
                    want.src_a = !phase;
                    want.snk_b = !phase;
                end
            end
            DEC_SLOW: begin
                if (sync_slow) begin
                    want.snk_a = 1'b1;
                    want.snk_b = 1'b1;
                end else begin
                    want.snk_b = phase;
                    want.snk_a = !phase;
                end
            end
            default: want = '0;
        endcase
    end
endmodule

// File: rtl/hb_fault_gate.sv
module hb_fault_gate
    import hb_gate_pkg::*;
#(
    parameter int HARD_FAULTS = 3
) (
    input  gates_t                 want,
    input  logic [HARD_FAULTS-1:0] hard_flt,
    input  logic                   cp_low,
    output gates_t                 safe
);
    always_comb begin
        safe = want;
        if (cp_low) begin
            safe.src_a = 1'b0;
            safe.src_b = 1'b0;
        end
        if (|hard_flt) begin
            safe = '0;
        end
    end
endmodule

// File: rtl/hb_break_seq.sv
module hb_break_seq
    import hb_gate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  gates_t target,
    output gates_t gates
);
    seq_e   state_q, state_d;
    gates_t held_q, held_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_OFF: begin
                if (target != '0) begin
                    state_d = ST_ON;
                    held_d  = target;
                end
            end
            ST_ON: begin
                if (target != held_q) begin
                    state_d = ST_BREAK;
                    held_d  = '0;
                end
            end
            ST_BREAK: begin
                if (target != '0) begin
                    state_d = ST_ON;
                    held_d  = target;
                end else begin
                    state_d = ST_OFF;
                end
            end
            default: begin
                state_d = ST_OFF;
                held_d  = '0;
            end
        endcase
    end

    always_comb begin
        gates = (state_q == ST_ON) ? held_q : '0;
    end
endmodule

// File: rtl/hb_gate_decoder.sv
module hb_gate_decoder
    import hb_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_i,
    input  logic       src_latch_i,
    input  logic [1:0] decay_i,
    input  logic [1:0] sr_mode_i,
    input  logic       zero_cur_i,
    input  logic       ot_flt_i,
    input  logic       cp_low_i,
    input  logic       reg_low_i,
    input  logic       vdd_low_i,
    output logic       src_a_o,
    output logic       src_b_o,
    output logic       snk_a_o,
    output logic       snk_b_o
);
    localparam int HARD_N = 3;

    gates_t             want;
    gates_t             safe;
    gates_t             gates;
    logic [HARD_N-1:0]  hard_flt;

    assign hard_flt = {ot_flt_i, reg_low_i, vdd_low_i};

    hb_path_decode u_path (
        .phase     (phase_i),
        .src_latch (src_latch_i),
        .decay     (decay_i),
        .sr_mode   (sr_mode_i),
        .zero_cur  (zero_cur_i),
        .want      (want)
    );

    hb_fault_gate #(.HARD_FAULTS(HARD_N)) u_fault (
        .want     (want),
        .hard_flt (hard_flt),
        .cp_low   (cp_low_i),
        .safe     (safe)
    );

    hb_break_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .target (safe),
        .gates  (gates)
    );

    assign src_a_o = gates.src_a;
    assign src_b_o = gates.src_b;
    assign snk_a_o = gates.snk_a;
    assign snk_b_o = gates.snk_b;
endmodule

// File: rtl/hb_gate_decoder_chk.sv
module hb_gate_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] decay_i,
    input logic [1:0] sr_mode_i,
    input logic       ot_flt_i,
    input logic       cp_low_i,
    input logic       reg_low_i,
    input logic       vdd_low_i,
    input logic       src_a_o,
    input logic       src_b_o,
    input logic       snk_a_o,
    input logic       snk_b_o
);
    logic [3:0] outs;
    logic       hard;
    assign outs = {src_a_o, src_b_o, snk_a_o, snk_b_o};
    assign hard = ot_flt_i | reg_low_i | vdd_low_i;

    p_leg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o));

    p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|outs) |=> (outs == $past(outs)) || (outs == 4'b0000));

    p_hard_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hard |=> (outs == 4'b0000));

    p_cp_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_low_i |=> (!src_a_o && !src_b_o));

    p_fast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_i == 2'b01 && (sr_mode_i == 2'b00 || sr_mode_i == 2'b11)) |=> (outs == 4'b0000));

    p_slow_brake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_i == 2'b10) |=> (!src_a_o && !src_b_o));

    p_rsvd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (decay_i == 2'b11) |=> (outs == 4'b0000));
endmodule

bind hb_gate_decoder hb_gate_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .decay_i   (decay_i),
    .sr_mode_i (sr_mode_i),
    .ot_flt_i  (ot_flt_i),
    .cp_low_i  (cp_low_i),
    .reg_low_i (reg_low_i),
    .vdd_low_i (vdd_low_i),
    .src_a_o   (src_a_o),
    .src_b_o   (src_b_o),
    .snk_a_o   (snk_a_o),
    .snk_b_o   (snk_b_o)
);

// File: tb/hb_gate_decoder_tb_top.sv
`timescale 1ns/1ps
module hb_gate_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_i = 1'b0, src_latch_i = 1'b0, zero_cur_i = 1'b0;
    logic [1:0] decay_i = 2'b11, sr_mode_i = 2'b00;
    logic ot_flt_i = 1'b0, cp_low_i = 1'b0, reg_low_i = 1'b0, vdd_low_i = 1'b0;
    logic src_a_o, src_b_o, snk_a_o, snk_b_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;
    string tag = "R9";
    logic [3:0] exp_q = 4'b0000;

    always #2 clk = ~clk;

    hb_gate_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .src_latch_i(src_latch_i),
        .decay_i(decay_i), .sr_mode_i(sr_mode_i), .zero_cur_i(zero_cur_i),
        .ot_flt_i(ot_flt_i), .cp_low_i(cp_low_i), .reg_low_i(reg_low_i),
        .vdd_low_i(vdd_low_i), .src_a_o(src_a_o), .src_b_o(src_b_o),
        .snk_a_o(snk_a_o), .snk_b_o(snk_b_o)
    );

    function automatic logic [3:0] outs();
        return {src_a_o, src_b_o, snk_a_o, snk_b_o};
    endfunction

    // Reference target, bit order {src_a, src_b, snk_a, snk_b}
    function automatic logic [3:0] ref_target();
        logic [3:0] r;
        bit sync_on;
        sync_on = (sr_mode_i == 2'b01) || (sr_mode_i == 2'b10);
        r = 4'b0000;
        if (decay_i == 2'b00) begin
            if (phase_i) r = {src_latch_i, 1'b0, 1'b0, 1'b1};
            else         r = {1'b0, src_latch_i, 1'b1, 1'b0};
        end else if (decay_i == 2'b01) begin
            if (sr_mode_i == 2'b10 || (sr_mode_i == 2'b01 && !zero_cur_i))
                r = phase_i ? 4'b0110 : 4'b1001;
        end else if (decay_i == 2'b10) begin
            if (sync_on) r = 4'b0011;
            else         r = phase_i ? 4'b0001 : 4'b0010;
        end
        if (cp_low_i) r = r & 4'b0011;
        if (ot_flt_i || reg_low_i || vdd_low_i) r = 4'b0000;
        return r;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) exp_q <= 4'b0000;
        else if (exp_q == 4'b0000) exp_q <= ref_target();
        else if (ref_target() != exp_q) exp_q <= 4'b0000;
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: outputs act=%b exp=%b at cycle %0d", req, act, expv, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) check(tag, outs(), rst_n ? exp_q : 4'b0000);
    end

    task automatic drive(input string t, input logic ph, input logic lat, input logic [1:0] dc,
                         input logic [1:0] md, input logic zc, input logic [3:0] flt);
        @(negedge clk);
        tag = t;
        phase_i = ph; src_latch_i = lat; decay_i = dc; sr_mode_i = md; zero_cur_i = zc;
        {ot_flt_i, cp_low_i, reg_low_i, vdd_low_i} = flt;
    endtask

    task automatic settle_check(input string t, input logic [3:0] expv);
        repeat (3) @(negedge clk);
        #0.5 check(t, outs(), expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5 check("R9", outs(), 4'b0000);      // reset state
        @(negedge clk); rst_n = 1'b1;

        // R9: from all-off the new pattern shows after one edge
        drive("R9", 1, 1, 2'b00, 2'b00, 0, 4'b0000);
        @(negedge clk); #0.5 check("R9", outs(), 4'b1001);
        settle_check("R1", 4'b1001);
        // R8: polarity flip goes through one all-off cycle
        drive("R8", 0, 1, 2'b00, 2'b00, 0, 4'b0000);
        @(negedge clk); #0.5 check("R8", outs(), 4'b0000);
        @(negedge clk); #0.5 check("R8", outs(), 4'b0110);
        drive("R1", 1, 0, 2'b00, 2'b00, 0, 4'b0000); settle_check("R1", 4'b0001);
        drive("R1", 0, 0, 2'b00, 2'b10, 0, 4'b0000); settle_check("R1", 4'b0010);
        drive("R2", 1, 1, 2'b01, 2'b10, 0, 4'b0000); settle_check("R2", 4'b0110);
        drive("R2", 0, 1, 2'b01, 2'b10, 1, 4'b0000); settle_check("R2", 4'b1001);
        drive("R3", 1, 1, 2'b01, 2'b01, 0, 4'b0000); settle_check("R3", 4'b0110);
        drive("R3", 1, 1, 2'b01, 2'b01, 1, 4'b0000); settle_check("R3", 4'b0000);
        drive("R4", 1, 1, 2'b01, 2'b00, 0, 4'b0000); settle_check("R4", 4'b0000);
        drive("R4", 0, 1, 2'b01, 2'b11, 0, 4'b0000); settle_check("R4", 4'b0000);
        drive("R4", 1, 1, 2'b10, 2'b00, 0, 4'b0000); settle_check("R4", 4'b0001);
        drive("R4", 0, 1, 2'b10, 2'b11, 0, 4'b0000); settle_check("R4", 4'b0010);
        drive("R5", 1, 1, 2'b10, 2'b01, 1, 4'b0000); settle_check("R5", 4'b0011);
        drive("R5", 0, 1, 2'b10, 2'b10, 0, 4'b0000); settle_check("R5", 4'b0011);
        drive("R6", 1, 1, 2'b00, 2'b10, 0, 4'b1000); settle_check("R6", 4'b0000);
        drive("R6", 1, 1, 2'b00, 2'b10, 0, 4'b0010); settle_check("R6", 4'b0000);
        drive("R6", 0, 1, 2'b10, 2'b10, 0, 4'b0001); settle_check("R6", 4'b0000);
        drive("R7", 1, 1, 2'b00, 2'b10, 0, 4'b0100); settle_check("R7", 4'b0001);
        drive("R7", 1, 1, 2'b01, 2'b10, 0, 4'b0100); settle_check("R7", 4'b0010);
        drive("R10", 1, 1, 2'b11, 2'b10, 0, 4'b0000); settle_check("R10", 4'b0000);

        // R8: random sweep, model compared on every clock
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] f;
            f = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'b0000;
            drive("R8", 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                  1'($urandom), f);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule